// File: doc/BRIEF.md
# TDM Time-Slot Serial Port

This block is the slave end of a time-division-multiplexed serial link. An external data clock and an external frame sync arrive as plain inputs. The block samples them with its own faster system clock, finds their edges, and uses them to step through the eight-bit time slots of each frame. Each of its two serial ports has one data input, one data output and an output enable. On every port the block shifts out transmit bytes from a 64-entry slot buffer and collects received bytes into a second 64-entry buffer, stored at the index of the slot they arrived in.

The frame length is 6, 12, 32 or 64 slots. In the 64-slot setting the whole buffer serves port 0, so port 1 is switched off. A second setting stretches each bit over two data-clock periods, so the same frame works with a data clock at twice the bit rate. A host-side write port fills the transmit buffers and a read port returns the receive buffers. Pulses mark the start and the completion of each frame.

Top module: `tdm_slot_port`

## Requirements
- R1: `slotMode` selects the slots per frame: 0 gives 6, 1 gives 12, 2 gives 32, 3 gives 64. Each enabled port carries slots 0 to N-1, eight bits each, most significant bit first.
- R2: The frame sync is sampled at every falling data-clock edge. A sample of 1 that follows a sample of 0 starts a frame and raises `frameStart` for exactly one system clock. Bit 7 of slot 0 is launched at the next rising edge.
- R3: With `dblRate` = 0, `dOut` changes only on rising data-clock edges, one bit per clock period. `dIn` is captured on the falling edge of the same period.
- R4: With `dblRate` = 1, each bit lasts two data-clock periods counted from the frame start. `dOut` changes only on the first rising edge of a bit and holds through the second period. `dIn` is captured on the second falling edge.
- R5: In 64-slot mode, `dOe[1]` stays low for the whole frame and the port 1 receive buffer is not written.
- R6: Bit periods after the last configured slot and before the next frame start are ignored. They write no receive entry, the other entries keep their contents, and every enabled `dOut` is held at 1 with its enable high.
- R7: A frame start restarts the bit and slot count at once, even when the previous frame was cut short. A frame that was cut short gives no `frameDone`.
- R8: When the last bit of a slot is captured, the received byte is written to that slot's index in the receive buffer. After the last slot, `frameDone` pulses for exactly one system clock.
- R9: `slotMode` and `dblRate` are latched at frame start. Changing them inside a frame has no effect until the next frame.
- R10: After reset, and until the first frame start, both `dOe` bits are low.
- R11: A host write (`wrEn`, `wrPort`, `wrAddr`, `wrData`) sets the transmit byte for that port and slot. `rdData` returns, without a clock delay, the receive byte selected by `rdPort` and `rdAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dclIn | input | 1 | External data clock (asynchronous) |
| fscIn | input | 1 | External frame sync (asynchronous) |
| slotMode | input | 2 | Frame length select: 0=6, 1=12, 2=32, 3=64 slots |
| dblRate | input | 1 | 1 = two data-clock periods per bit |
| dOut | output | 2 | Serial data out, one bit per port |
| dOe | output | 2 | Output enable, one bit per port |
| dIn | input | 2 | Serial data in, one bit per port |
| wrEn | input | 1 | Transmit buffer write strobe |
| wrPort | input | 1 | Port selected for the write |
| wrAddr | input | 6 | Slot index for the write |
| wrData | input | 8 | Transmit byte |
| rdPort | input | 1 | Port selected for the read |
| rdAddr | input | 6 | Slot index for the read |
| rdData | output | 8 | Receive byte read out |
| frameStart | output | 1 | One-cycle pulse when a frame start is found |
| frameDone | output | 1 | One-cycle pulse after the last slot is received |

## Verification
The assertions assume that each data-clock phase lasts well over three system clocks, so that every synchronized edge is seen exactly once and edges alternate. They also assume that the frame sync and serial inputs change only near rising data-clock edges, so that they are stable when a falling edge is sampled. The stimulus keeps within this. Every input change is made right after the bench raises the data clock, each clock phase is held for six system clocks, and at least one low frame-sync sample comes before each frame start. Random bytes, modes and rates vary the data within these limits.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int PORTS      = 2;
  localparam int SLOT_BITS  = 8;
  localparam int MAX_SLOTS  = 64;
  localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
  localparam int SLOT_CNT_W = SLOT_IDX_W + 1;
  localparam int BIT_IDX_W  = $clog2(SLOT_BITS);
  localparam int PORT_W     = $clog2(PORTS);

  // strobes from the frame controller to the slot datapath
  typedef struct packed {
    logic                  launch;   // drive next bit
    logic                  sample;   // capture input bit
    logic                  inSlots;  // current bit belongs to a configured slot
    logic [BIT_IDX_W-1:0]  bitIdx;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic                  lastBit;
    logic [PORTS-1:0]      portEn;
  } tdmStrobes_t;

  function automatic logic [SLOT_CNT_W-1:0] slotsFor(input logic [1:0] mode);
    case (mode)
      2'd0:    return SLOT_CNT_W'(6);
      2'd1:    return SLOT_CNT_W'(12);
      2'd2:    return SLOT_CNT_W'(32);
      default: return SLOT_CNT_W'(MAX_SLOTS);
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dclIn,
  input  logic        fscIn,
  input  logic [1:0]  slotMode,
  input  logic        dblRate,
  output tdmStrobes_t str,
  output logic        frameStart,
  output logic        frameDone
);
  logic [SYNC_STAGES-1:0] dclSync, fscSync;
  logic dclPrev, fscLast, started, dblQ;
  logic [1:0] modeQ, edgeCnt;
  logic [BIT_IDX_W-1:0]  bitCnt;
  logic [SLOT_CNT_W-1:0] slotCnt;

  logic dclNow, riseEv, fallEv, fsDet, launch, sample, inSlots, endSlot;
  logic [1:0] lastEdge;
  logic [SLOT_CNT_W-1:0] nSlots;

  assign dclNow   = dclSync[SYNC_STAGES-1];
  assign riseEv   = dclNow & ~dclPrev;
  assign fallEv   = ~dclNow & dclPrev;
  assign fsDet    = fallEv & fscSync[SYNC_STAGES-1] & ~fscLast;
  assign nSlots   = slotsFor(modeQ);
  assign lastEdge = dblQ ? 2'd3 : 2'd1;
  assign inSlots  = started && (slotCnt < nSlots);
  assign launch   = started && riseEv && (edgeCnt == 2'd0);
  assign sample   = started && fallEv && (edgeCnt == lastEdge);
  assign endSlot  = bitCnt == BIT_IDX_W'(SLOT_BITS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dclSync <= '0; fscSync <= '0; dclPrev <= 1'b0; fscLast <= 1'b1;
      started <= 1'b0; modeQ <= 2'd0; dblQ <= 1'b0; edgeCnt <= 2'd0;
      bitCnt <= '0; slotCnt <= '0; frameStart <= 1'b0; frameDone <= 1'b0;
    end else begin
      dclSync    <= {dclSync[SYNC_STAGES-2:0], dclIn};
      fscSync    <= {fscSync[SYNC_STAGES-2:0], fscIn};
      dclPrev    <= dclNow;
      frameStart <= fsDet;
      frameDone  <= sample && inSlots && endSlot && (slotCnt == nSlots - 1'b1);
      if (fallEv) fscLast <= fscSync[SYNC_STAGES-1];
      if (fsDet) begin
        started <= 1'b1;
        modeQ   <= slotMode;
        dblQ    <= dblRate;
        edgeCnt <= 2'd0;
        bitCnt  <= '0;
        slotCnt <= '0;
      end else if (started && (riseEv || fallEv)) begin
        edgeCnt <= (fallEv && edgeCnt == lastEdge) ? 2'd0 : edgeCnt + 2'd1;
        if (sample) begin
          bitCnt <= bitCnt + 1'b1;
          if (endSlot && inSlots) slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    str.launch  = launch;
    str.sample  = sample;
    str.inSlots = inSlots;
    str.bitIdx  = bitCnt;
    str.slotIdx = slotCnt[SLOT_IDX_W-1:0];
    str.lastBit = endSlot;
    for (int p = 0; p < PORTS; p++)
      str.portEn[p] = started && !(p != 0 && modeQ == 2'd3);
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    fsDet |=> (started && slotCnt == '0 && bitCnt == '0 && edgeCnt == 2'd0));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= nSlots);
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fsDet |=> ($stable(modeQ) && $stable(dblQ)));
endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tdmStrobes_t           str,
  input  logic [PORTS-1:0]      dIn,
  input  logic                  wrEn,
  input  logic [PORT_W-1:0]     wrPort,
  input  logic [SLOT_IDX_W-1:0] wrAddr,
  input  logic [SLOT_BITS-1:0]  wrData,
  input  logic [PORT_W-1:0]     rdPort,
  input  logic [SLOT_IDX_W-1:0] rdAddr,
  output logic [SLOT_BITS-1:0]  rdData,
  output logic [PORTS-1:0]      dOut,
  output logic [PORTS-1:0]      dOe
);
  logic [SLOT_BITS-1:0] rdByte [PORTS];
  logic [BIT_IDX_W-1:0] bitSel;
  assign bitSel = BIT_IDX_W'(SLOT_BITS - 1) - str.bitIdx;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SLOT_BITS-1:0]   txMem [MAX_SLOTS];
    logic [SLOT_BITS-1:0]   rxMem [MAX_SLOTS];
    logic [SYNC_STAGES-1:0] inSync;
    logic [SLOT_BITS-2:0]   rxShift;
    logic outBit, oeBit, inBit, takeBit;

    assign inBit   = inSync[SYNC_STAGES-1];
    assign takeBit = str.sample && str.inSlots && str.portEn[p];

    always_ff @(posedge clk)
      if (wrEn && wrPort == PORT_W'(p)) txMem[wrAddr] <= wrData;

    always_ff @(posedge clk)
      if (takeBit && str.lastBit) rxMem[str.slotIdx] <= {rxShift, inBit};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inSync <= '0; rxShift <= '0; outBit <= 1'b1; oeBit <= 1'b0;
      end else begin
        inSync <= {inSync[SYNC_STAGES-2:0], dIn[p]};
        oeBit  <= str.portEn[p];
        if (str.launch) outBit <= str.inSlots ? txMem[str.slotIdx][bitSel] : 1'b1;
        if (takeBit) rxShift <= {rxShift[SLOT_BITS-3:0], inBit};
      end
    end

    assign dOut[p]   = outBit;
    assign dOe[p]    = oeBit;
    assign rdByte[p] = rxMem[rdAddr];
  end

  assign rdData = rdByte[rdPort];

  assert_port1_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !str.portEn[1] |=> !dOe[1]);
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !str.launch |=> $stable(dOut));
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (str.launch && !str.inSlots) |=> (dOut == '1));
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dclIn,
  input  logic                  fscIn,
  input  logic [1:0]            slotMode,
  input  logic                  dblRate,
  output logic [PORTS-1:0]      dOut,
  output logic [PORTS-1:0]      dOe,
  input  logic [PORTS-1:0]      dIn,
  input  logic                  wrEn,
  input  logic [PORT_W-1:0]     wrPort,
  input  logic [SLOT_IDX_W-1:0] wrAddr,
  input  logic [SLOT_BITS-1:0]  wrData,
  input  logic [PORT_W-1:0]     rdPort,
  input  logic [SLOT_IDX_W-1:0] rdAddr,
  output logic [SLOT_BITS-1:0]  rdData,
  output logic                  frameStart,
  output logic                  frameDone
);
  tdmStrobes_t str;

  tdm_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .dclIn(dclIn), .fscIn(fscIn),
    .slotMode(slotMode), .dblRate(dblRate), .str(str),
    .frameStart(frameStart), .frameDone(frameDone));

  tdm_slot_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rstN(rstN), .str(str), .dIn(dIn),
    .wrEn(wrEn), .wrPort(wrPort), .wrAddr(wrAddr), .wrData(wrData),
    .rdPort(rdPort), .rdAddr(rdAddr), .rdData(rdData),
    .dOut(dOut), .dOe(dOe));
endmodule

// File: tb/tdm_slot_port_bench.sv
`timescale 1ns/1ps
module tdm_slot_port_bench;
  localparam int H = 6;  // system clocks per data-clock phase

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic dcl = 1'b0, fsc = 1'b0, dblRate = 1'b0, wrEn = 1'b0, wrPort = 1'b0, rdPort = 1'b0;
  logic [1:0] slotMode = 2'd0, dIn = 2'b11;
  logic [5:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic [1:0] dOut, dOe;
  logic frameStart, frameDone;

  tdm_slot_port u_tdm_slot_port (
    .clk(clk), .rstN(rstN), .dclIn(dcl), .fscIn(fsc), .slotMode(slotMode),
    .dblRate(dblRate), .dOut(dOut), .dOe(dOe), .dIn(dIn), .wrEn(wrEn),
    .wrPort(wrPort), .wrAddr(wrAddr), .wrData(wrData), .rdPort(rdPort),
    .rdAddr(rdAddr), .rdData(rdData), .frameStart(frameStart), .frameDone(frameDone));

  int errors = 0, checks = 0, fsCnt = 0, fdCnt = 0, midBitChange = 0;
  logic [7:0] txExp [2][64];
  logic [7:0] sendRx [2][64];
  logic [7:0] rxModel [2][64];
  logic [7:0] capTx [2][64];
  bit rxKnown [2][64];

  always @(posedge clk) begin
    if (frameStart) fsCnt++;
    if (frameDone) fdCnt++;
  end

  function automatic int slotsOf(input logic [1:0] m);
    case (m) 2'd0: return 6; 2'd1: return 12; 2'd2: return 32; default: return 64; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int p, input int a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrPort = p[0]; wrAddr = a[5:0]; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic hostRead(input int p, input int a, output logic [7:0] d);
    @(negedge clk); rdPort = p[0]; rdAddr = a[5:0]; #1 d = rdData;
  endtask

  task automatic idleCycle();
    @(negedge clk); dcl = 1'b1; repeat (H-1) @(negedge clk);
    @(negedge clk); dcl = 1'b0; repeat (H-1) @(negedge clk);
  endtask

  task automatic startFrame();
    @(negedge clk); dcl = 1'b1; fsc = 1'b1; repeat (H-1) @(negedge clk);
    @(negedge clk); dcl = 1'b0; repeat (H-1) @(negedge clk);
  endtask

  task automatic bitPeriod(input bit dbl, input logic [1:0] inBits,
                           output logic [1:0] o, output logic [1:0] oe);
    @(negedge clk); dcl = 1'b1; fsc = 1'b0; dIn = inBits;
    repeat (H-1) @(negedge clk); o = dOut; oe = dOe;
    @(negedge clk); dcl = 1'b0; repeat (H-1) @(negedge clk);
    if (dbl) begin
      @(negedge clk); dcl = 1'b1; repeat (H-1) @(negedge clk);
      if (dOut != o) midBitChange++;
      @(negedge clk); dcl = 1'b0; repeat (H-1) @(negedge clk);
    end
  endtask

  task automatic runFrame(input logic [1:0] mode, input bit dbl, input int abortBits,
                          input int spare, input bit changeMode, input logic [1:0] laterMode);
    int nS, fs0, fd0, total, oeMis, idleBad;
    logic [1:0] en, o, oe, inBits;
    logic [7:0] rd;
    nS = slotsOf(mode); oeMis = 0; idleBad = 0; midBitChange = 0;
    en = {mode != 2'd3, 1'b1};
    @(negedge clk); slotMode = mode; dblRate = dbl;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 64; s++) begin
        txExp[p][s] = 8'($urandom);
        sendRx[p][s] = 8'($urandom);
        hostWrite(p, s, txExp[p][s]);
      end
    fs0 = fsCnt; fd0 = fdCnt;
    startFrame();
    if (changeMode) begin slotMode = laterMode; dblRate = ~dbl; end
    total = (abortBits >= 0) ? abortBits : nS * 8;
    for (int b = 0; b < total; b++) begin
      for (int p = 0; p < 2; p++) inBits[p] = sendRx[p][b/8][7 - b%8];
      bitPeriod(dbl, inBits, o, oe);
      for (int p = 0; p < 2; p++) capTx[p][b/8][7 - b%8] = o[p];
      if (oe != en) oeMis++;
    end
    if (abortBits >= 0) begin
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < abortBits/8; s++)
          if (en[p]) begin rxModel[p][s] = sendRx[p][s]; rxKnown[p][s] = 1'b1; end
      repeat (4) @(negedge clk);
      chk(fsCnt == fs0 + 1, "R7 cut frame start count", fsCnt - fs0, 1);
      chk(fdCnt == fd0, "R7 cut frame gives no done", fdCnt - fd0, 0);
      return;
    end
    for (int k = 0; k < spare; k++) begin
      bitPeriod(dbl, 2'($urandom), o, oe);
      if ((o & en) != en || oe != en) idleBad++;
    end
    repeat (4) @(negedge clk);
    chk(fsCnt == fs0 + 1, "R2 one-cycle frameStart", fsCnt - fs0, 1);
    chk(fdCnt == fd0 + 1, "R8 one-cycle frameDone", fdCnt - fd0, 1);
    chk(oeMis == 0, (mode == 2'd3) ? "R5 port1 enable low" : "R1 enables high", oeMis, 0);
    if (dbl) chk(midBitChange == 0, "R4 output held over bit", midBitChange, 0);
    if (spare > 0) chk(idleBad == 0, "R6 idle-high after last slot", idleBad, 0);
    for (int p = 0; p < 2; p++)
      if (en[p])
        for (int s = 0; s < nS; s++)
          chk(capTx[p][s] == txExp[p][s], dbl ? "R4 tx slot byte" : "R3 tx slot byte",
              capTx[p][s], txExp[p][s]);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < nS; s++)
        if (en[p]) begin rxModel[p][s] = sendRx[p][s]; rxKnown[p][s] = 1'b1; end
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 64; s++)
        if (rxKnown[p][s]) begin
          hostRead(p, s, rd);
          if (en[p] && s < nS) chk(rd == rxModel[p][s], "R8 R11 rx byte", rd, rxModel[p][s]);
          else if (!en[p])     chk(rd == rxModel[p][s], "R5 port1 rx untouched", rd, rxModel[p][s]);
          else                 chk(rd == rxModel[p][s], "R6 rx beyond frame untouched", rd, rxModel[p][s]);
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int p = 0; p < 2; p++) for (int s = 0; s < 64; s++) rxKnown[p][s] = 1'b0;
    repeat (4) @(negedge clk);
    chk(dOe == 2'b00, "R10 enables low in reset", dOe, 0);
    rstN = 1'b1;
    repeat (3) idleCycle();
    chk(dOe == 2'b00, "R10 enables low before frame", dOe, 0);
    chk(dOut == 2'b11, "R10 output idle before frame", dOut, 2'b11);
    runFrame(2'd3, 1'b0, -1, 4, 1'b0, 2'd0);  // R1 R5 64 slots
    runFrame(2'd2, 1'b1, -1, 2, 1'b0, 2'd0);  // R4 double rate
    runFrame(2'd0, 1'b0, -1, 6, 1'b0, 2'd0);  // R6 short frame
    runFrame(2'd0, 1'b0, -1, 5, 1'b1, 2'd1);  // R9 change ignored
    runFrame(2'd1, 1'b0, -1, 3, 1'b0, 2'd0);  // R9 change applied next frame
    runFrame(2'd2, 1'b0, 21, 0, 1'b0, 2'd0);  // R7 cut short
    runFrame(2'd2, 1'b0, -1, 2, 1'b0, 2'd0);  // R7 restart clean
    runFrame(2'd3, 1'b1, -1, 2, 1'b0, 2'd0);  // R5 R4 64 slots double
    for (int i = 0; i < 3; i++)
      runFrame(2'($urandom), 1'($urandom), -1, 1 + ($urandom % 4), 1'b0, 2'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule